// File: doc/BRIEF.md
# Wildcard Time Alarm Comparator

This block decides, once per second, whether the current time of day has reached a programmed alarm time. It takes three alarm bytes (seconds, minutes, hours) and three current-time bytes. An external timekeeper raises a one-cycle update strobe after it has loaded each new second into the time bytes. On that strobe the block compares the two sets of bytes field by field. On a match it emits a single-cycle alarm pulse, which the interrupt status logic uses to set its alarm flag.

Any alarm byte can be marked "don't care". Such a field matches every current value. Marking fields this way turns the alarm into a daily, hourly, per-minute or per-second event. Both sides of each field are decoded before the comparison. A control input selects BCD or binary coding. In 12-hour mode the hour field carries its PM marker in the most significant bit, and that hour is normalised to a 0..23 value.

A separate wakeup request pulse goes out alongside the alarm pulse, but only while the alarm interrupt enable is high. While the timekeeper is frozen for programming, no alarm is produced.

Top module: `time_alarm_match`

## Requirements
- R1: During and directly after reset, `alm_hit` and `wake_req` are 0.
- R2: When `upd_stb` is sampled high with `set_mode` low and every field matching, `alm_hit` is 1 for exactly the next clock cycle. In binary mode with 24-hour coding, identical alarm and current bytes always match.
- R3: Without `upd_stb`, no pulse is produced, even when the fields match.
- R4: An alarm byte whose bits 7 and 6 are both 1 is a wildcard. The wildcard test uses the raw byte before any decoding, so 0xC5 is a wildcard in both coding modes. With all three alarm bytes set to wildcards, every strobe produces a pulse.
- R5: Non-wildcard fields decode as BCD when `bin_mode`=0, as 10×bits[7:4]+bits[3:0]. They are taken unchanged when `bin_mode`=1. The comparison uses the decoded values, so in BCD mode 0x10 matches 0x0A, but in binary mode it does not.
- R6: When `hr24`=0, both hour bytes decode as follows: bits[6:0] are decoded, reduced modulo 12, and increased by 12 when bit 7 (PM) is 1. As a result, 0x12 matches 0x00, 0x92 matches 0x80, and 0x81 does not match 0x01 (BCD).
- R7: When `hr24`=1, the hour bytes decode as full 8-bit values with no PM handling. In BCD mode 0x12 does not match 0x00, and 0x92 does not match 0x80.
- R8: While `set_mode` is 1 at the strobe, no pulse is produced.
- R9: `wake_req` pulses together with `alm_hit` only when `alm_en` was 1 at the strobe. `alm_hit` does not depend on `alm_en`.
- R10: Wildcards act per field. With the minutes alarm byte a wildcard, a pulse requires the seconds and hours to match, whatever the current minutes value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | One-cycle strobe after the new second is loaded |
| set_mode | input | 1 | Timekeeper frozen for programming; suppresses alarms |
| bin_mode | input | 1 | 1 = binary coding, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| alm_en | input | 1 | Alarm interrupt enable; gates the wakeup request |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alm_hit | output | 1 | Single-cycle alarm-match pulse |
| wake_req | output | 1 | Single-cycle wakeup request |

## Verification
Both outputs are registered once. A strobe sampled at a rising edge therefore shows its result during the following cycle, and by the cycle after that the pulse has dropped back to 0. The bench applies the inputs and the strobe at a falling edge and removes the strobe at the next falling edge. It reads the pulse there, half a cycle after the edge that registered it, and reads the return to zero one cycle later. Checks of the no-strobe and frozen cases sample at the same falling edges, so a pulse that arrives one cycle late is still caught.

// File: rtl/tam_pkg.sv
package tam_pkg;
   localparam int DIGIT_W = 4;
   localparam int BYTE_W  = 2 * DIGIT_W;
   localparam int NUM_FIELDS = 3;
   localparam int HALF_DAY   = 12;

   typedef logic [BYTE_W-1:0] tbyte_t;

   typedef enum int {
      FLD_SEC = 0,
      FLD_MIN = 1,
      FLD_HR  = 2
   } field_e;

   // don't-care marker: the two upper bits both set in the raw byte
   function automatic logic is_wild(input tbyte_t b);
      return b[BYTE_W-1] & b[BYTE_W-2];
   endfunction

   // two packed decimal digits to a binary value
   function automatic tbyte_t bcd_to_bin(input tbyte_t b);
      tbyte_t hi;
      tbyte_t lo;
      hi = tbyte_t'(b[BYTE_W-1:DIGIT_W]);
      lo = tbyte_t'(b[DIGIT_W-1:0]);
      return tbyte_t'(hi * tbyte_t'(10)) + lo;
   endfunction
endpackage

// File: rtl/tam_field_decode.sv
module tam_field_decode
   import tam_pkg::*;
#(
   parameter bit IS_HOUR = 1'b0,
   parameter bit HR12_EN = 1'b1
) (
   input  tbyte_t raw,
   input  logic   bin_mode,
   input  logic   hr24,
   output tbyte_t val
);
   tbyte_t full_dec;

   always_comb begin
      full_dec = bin_mode ? raw : bcd_to_bin(raw);
   end

   generate
      if (IS_HOUR && HR12_EN) begin : g_hr12
         tbyte_t body;
         tbyte_t body_dec;
         tbyte_t h12_val;
         always_comb begin
            body     = {1'b0, raw[BYTE_W-2:0]};
            body_dec = bin_mode ? body : bcd_to_bin(body);
            h12_val  = tbyte_t'(body_dec % tbyte_t'(HALF_DAY))
                     + (raw[BYTE_W-1] ? tbyte_t'(HALF_DAY) : tbyte_t'(0));
            val      = hr24 ? full_dec : h12_val;
         end
      end else begin : g_plain
         logic unused_hr24;
         assign unused_hr24 = hr24;
         assign val = full_dec;
      end
   endgenerate
endmodule

// File: rtl/tam_match_core.sv
module tam_match_core
   import tam_pkg::*;
#(
   parameter int NF = NUM_FIELDS
) (
   input  logic [NF-1:0]             wild,
   input  logic [NF-1:0][BYTE_W-1:0] a_val,
   input  logic [NF-1:0][BYTE_W-1:0] c_val,
   output logic                      all_match
);
   logic [NF-1:0] fld_ok;

   generate
      for (genvar f = 0; f < NF; f++) begin : g_fld
         assign fld_ok[f] = wild[f] | (a_val[f] == c_val[f]);
      end
   endgenerate

   assign all_match = &fld_ok;
endmodule

// File: rtl/tam_pulse_reg.sv
module tam_pulse_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic wake_en,
   output logic hit,
   output logic wake
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit  <= 1'b0;
         wake <= 1'b0;
      end else begin
         hit  <= fire;
         wake <= fire & wake_en;
      end
   end
endmodule

// File: rtl/time_alarm_match.sv
module time_alarm_match
   import tam_pkg::*;
#(
   parameter int FIELD_W = tam_pkg::BYTE_W,
   parameter bit HR12_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_stb,
   input  logic               set_mode,
   input  logic               bin_mode,
   input  logic               hr24,
   input  logic               alm_en,
   input  logic [FIELD_W-1:0] alm_sec,
   input  logic [FIELD_W-1:0] alm_min,
   input  logic [FIELD_W-1:0] alm_hr,
   input  logic [FIELD_W-1:0] cur_sec,
   input  logic [FIELD_W-1:0] cur_min,
   input  logic [FIELD_W-1:0] cur_hr,
   output logic               alm_hit,
   output logic               wake_req
);
   localparam int NF = NUM_FIELDS;

   generate
      if (FIELD_W != BYTE_W) begin : g_bad_width
         $error("time_alarm_match: FIELD_W must equal two decimal digits");
      end
   endgenerate

   logic [NF-1:0][BYTE_W-1:0] alm_raw;
   logic [NF-1:0][BYTE_W-1:0] cur_raw;
   logic [NF-1:0][BYTE_W-1:0] alm_val;
   logic [NF-1:0][BYTE_W-1:0] cur_val;
   logic [NF-1:0]             alm_wild;
   logic                      all_match;
   logic                      fire;

   assign alm_raw[FLD_SEC] = alm_sec;
   assign alm_raw[FLD_MIN] = alm_min;
   assign alm_raw[FLD_HR]  = alm_hr;
   assign cur_raw[FLD_SEC] = cur_sec;
   assign cur_raw[FLD_MIN] = cur_min;
   assign cur_raw[FLD_HR]  = cur_hr;

   generate
      for (genvar f = 0; f < NF; f++) begin : g_dec
         localparam bit HOUR_F = (f == int'(FLD_HR));
         // wildcard taken from the undecoded byte
         assign alm_wild[f] = is_wild(alm_raw[f]);

         tam_field_decode #(.IS_HOUR(HOUR_F), .HR12_EN(HR12_EN)) u_alm_dec (
            .raw      (alm_raw[f]),
            .bin_mode (bin_mode),
            .hr24     (hr24),
            .val      (alm_val[f])
         );
         tam_field_decode #(.IS_HOUR(HOUR_F), .HR12_EN(HR12_EN)) u_cur_dec (
            .raw      (cur_raw[f]),
            .bin_mode (bin_mode),
            .hr24     (hr24),
            .val      (cur_val[f])
         );
      end
   endgenerate

   tam_match_core #(.NF(NF)) u_core (
      .wild      (alm_wild),
      .a_val     (alm_val),
      .c_val     (cur_val),
      .all_match (all_match)
   );

   assign fire = upd_stb & ~set_mode & all_match;

   tam_pulse_reg u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .wake_en (alm_en),
      .hit     (alm_hit),
      .wake    (wake_req)
   );
endmodule

// File: rtl/tam_alarm_chk.sv
module tam_alarm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       upd_stb,
   input logic       set_mode,
   input logic       bin_mode,
   input logic       hr24,
   input logic       alm_en,
   input logic [7:0] alm_sec,
   input logic [7:0] alm_min,
   input logic [7:0] alm_hr,
   input logic [7:0] cur_sec,
   input logic [7:0] cur_min,
   input logic [7:0] cur_hr,
   input logic       alm_hit,
   input logic       wake_req
);
   assert_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_stb |=> !alm_hit);

   assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_mode |=> !alm_hit);

   assert_wake_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> alm_hit);

   assert_wake_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !alm_en |=> !wake_req);

   assert_all_wild_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !set_mode && (alm_sec[7:6] == 2'b11) &&
       (alm_min[7:6] == 2'b11) && (alm_hr[7:6] == 2'b11)) |=> alm_hit);

   assert_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !set_mode && bin_mode && hr24 && (alm_sec == cur_sec) &&
       (alm_min == cur_min) && (alm_hr == cur_hr)) |=> alm_hit);
endmodule

bind time_alarm_match tam_alarm_chk u_chk (.*);

// File: tb/sim_time_alarm_match.sv
module sim_time_alarm_match;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_stb = 1'b0;
   logic       set_mode = 1'b0;
   logic       bin_mode = 1'b1;
   logic       hr24 = 1'b1;
   logic       alm_en = 1'b0;
   logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
   logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hr = 8'h00;
   logic       alm_hit, wake_req;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   time_alarm_match u0 (.*);

   function automatic int mdec(input logic [7:0] b, input bit binm, input bit hour, input bit h24);
      int v;
      int d;
      v = (hour && !h24) ? int'(b & 8'h7f) : int'(b);
      d = binm ? v : (v / 16) * 10 + (v % 16);
      if (hour && !h24) d = (d % 12) + (b[7] ? 12 : 0);
      return d & 255;
   endfunction

   function automatic bit fmatch(input logic [7:0] a, input logic [7:0] c,
                                 input bit binm, input bit hour, input bit h24);
      if (a[7:6] == 2'b11) return 1'b1;
      return mdec(a, binm, hour, h24) == mdec(c, binm, hour, h24);
   endfunction

   task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual hit/wake=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic apply(input string tag, input bit stb, input bit setm, input bit binm,
                        input bit h24, input bit en,
                        input logic [7:0] as, input logic [7:0] am, input logic [7:0] ah,
                        input logic [7:0] cs, input logic [7:0] cm, input logic [7:0] ch);
      bit exp;
      exp = stb && !setm && fmatch(as, cs, binm, 1'b0, h24) &&
            fmatch(am, cm, binm, 1'b0, h24) && fmatch(ah, ch, binm, 1'b1, h24);
      @(negedge clk);
      upd_stb = stb; set_mode = setm; bin_mode = binm; hr24 = h24; alm_en = en;
      alm_sec = as; alm_min = am; alm_hr = ah;
      cur_sec = cs; cur_min = cm; cur_hr = ch;
      @(negedge clk);
      upd_stb = 1'b0;
      check(tag, {alm_hit, wake_req}, {exp, exp & en});
      @(negedge clk);
      check({tag, " R2 pulse width"}, {alm_hit, wake_req}, 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", {alm_hit, wake_req}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {alm_hit, wake_req}, 2'b00);

      // R2: binary 24h exact match, 12:34:56
      apply("R2 exact", 1, 0, 1, 1, 1, 8'h38, 8'h22, 8'h0C, 8'h38, 8'h22, 8'h0C);
      apply("R2 one-off", 1, 0, 1, 1, 1, 8'h38, 8'h22, 8'h0C, 8'h39, 8'h22, 8'h0C);
      // R3: match without strobe
      apply("R3 no strobe", 0, 0, 1, 1, 1, 8'h38, 8'h22, 8'h0C, 8'h38, 8'h22, 8'h0C);
      // R4: all wildcards, 0xC5 wildcard in BCD too
      apply("R4 all wild bin", 1, 0, 1, 1, 1, 8'hC0, 8'hFF, 8'hC7, 8'h11, 8'h2A, 8'h05);
      apply("R4 all wild bcd", 1, 0, 0, 0, 1, 8'hC5, 8'hC5, 8'hC5, 8'h59, 8'h07, 8'h93);
      // R5: BCD decode
      apply("R5 bcd 0x10=0x0A", 1, 0, 0, 1, 1, 8'h10, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00);
      apply("R5 bin 0x10!=0x0A", 1, 0, 1, 1, 1, 8'h10, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00);
      // R6: 12-hour normalisation
      apply("R6 12AM", 1, 0, 0, 0, 1, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00);
      apply("R6 12PM", 1, 0, 0, 0, 1, 8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h80);
      apply("R6 PM bit", 1, 0, 0, 0, 1, 8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h01);
      // R7: 24-hour, no PM handling
      apply("R7 0x12 vs 0x00", 1, 0, 0, 1, 1, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00);
      apply("R7 0x92 vs 0x80", 1, 0, 0, 1, 1, 8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h80);
      // R8: frozen
      apply("R8 set mode", 1, 1, 1, 1, 1, 8'hC0, 8'hC0, 8'hC0, 8'h01, 8'h02, 8'h03);
      // R9: enable only gates wakeup
      apply("R9 enable off", 1, 0, 1, 1, 0, 8'h05, 8'h06, 8'h07, 8'h05, 8'h06, 8'h07);
      // R10: per-field wildcard
      apply("R10 hr miss", 1, 0, 0, 1, 1, 8'h30, 8'hC0, 8'h08, 8'h30, 8'h45, 8'h09);
      apply("R10 hr hit", 1, 0, 0, 1, 1, 8'h30, 8'hC0, 8'h08, 8'h30, 8'h45, 8'h08);

      // sweep covering R4 R5 R6 R7 R9 R10
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] c [3];
         logic [7:0] a [3];
         bit binm, h24, en, setm;
         binm = bit'($urandom % 2);
         h24  = bit'($urandom % 2);
         en   = bit'($urandom % 2);
         setm = (($urandom % 8) == 0);
         for (int f = 0; f < 3; f++) begin
            int k;
            c[f] = 8'($urandom);
            k = int'($urandom % 4);
            if (k == 0) a[f] = 8'hC0 | 8'($urandom % 64);
            else if (k == 1) a[f] = c[f];
            else if (k == 2) a[f] = c[f] ^ 8'h80;
            else a[f] = 8'($urandom);
         end
         apply("R10 sweep", 1, setm, binm, h24, en, a[0], a[1], a[2], c[0], c[1], c[2]);
      end

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule